// File: doc/BRIEF.md
# Configurable AND-OR Logic Array

This block is a combinational sum-of-products array whose whole personality sits in a configuration register. Eight dedicated inputs and ten bidirectional pins form eighteen variables, and each variable is offered to the AND plane in both true and inverted form. The pins are modelled as three separate signals: `b_in` carries the pin value, `b_out` carries the driven value and `b_oe` carries the driver enable. The value on `b_in` feeds back into the AND plane.

The AND plane forms 42 product terms. Terms 0 to 31 are logic terms. They feed a fully shared OR plane in which any term may join any or all of the ten sums, so a sum can be up to 32 terms wide. Each sum passes through its own polarity stage, an XOR with a configuration bit. Terms 32 to 41 are direction terms, one for each pin. A direction term decides whether that pin drives.

The configuration is loaded through a serial shift chain under `cfg_en`. The path from `i_in` and `b_in` to `b_out` and `b_oe` has no register in it.

Top module: `pla_array`

## Requirements
- R1: Each AND-plane literal has a 2-bit code {true_bit, complement_bit}. 10 passes the variable, 01 passes its inverse, 00 is don't care, and 11 forces the term false. A term whose literals are all don't care is true. Variables 0..7 are `i_in[7:0]` and variables 8..17 are `b_in[0..9]`.
- R2: Any of logic terms 0..31 can be connected to any subset of the ten sums, including all 32 terms on one sum. A sum with no connected term is 0 before the polarity stage.
- R3: Polarity bit k clear makes `b_out[k]` equal to sum k. Polarity bit k set makes `b_out[k]` the inverse of sum k.
- R4: With `cfg_en` low, `b_oe[k]` equals direction term 32+k.
- R5: The value on `b_in` takes part in the AND plane through variables 8..17, independently of `b_out`.
- R6: On each rising clock edge with `cfg_en` high, the chain shifts by one and takes `cfg_sdi` into chain index 0. After 1842 shifts, the first bit sent sits at index 1841. The layout is as follows:
  - Polarity bit k is at index k.
  - The OR bit joining term p to sum k is at index 10 + 10·p + k.
  - For term t and variable v, the true bit is at index 330 + 36·t + 2·v + 1 and the complement bit is at index 330 + 36·t + 2·v.
  - With `cfg_en` low the chain holds its value, whatever `cfg_sdi` does.
- R7: A synchronous active-high `rst` loads the unprogrammed configuration. In it every polarity bit is clear, every OR bit is set and every AND literal is 11. As a result `b_out` and `b_oe` are all zero.
- R8: While `cfg_en` is high, every `b_oe` bit is low, including in the cycle before the first shift.
- R9: `b_out` and `b_oe` follow changes on `i_in` and `b_in` with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration chain |
| rst | input | 1 | Synchronous active-high reset to the unprogrammed configuration |
| cfg_en | input | 1 | Shift enable for the configuration chain; also blocks all drivers |
| cfg_sdi | input | 1 | Serial configuration data, first bit ends at the top index |
| i_in | input | 8 | Dedicated inputs, variables 0..7 |
| b_in | input | 10 | Pin values fed back into the AND plane, variables 8..17 |
| b_out | output | 10 | Value each pin drives, after the polarity stage |
| b_oe | output | 10 | Per-pin driver enable from the direction terms |

## Verification
The bench builds the block with its default sizes: 8 inputs, 10 pins and 32 logic terms, which gives a 1842-bit chain. At these sizes every index formula in the layout requirement is exercised in full. The bench can place all 32 terms on one sum, use the last direction term and reach variable 17 through pin feedback. Each configuration is shifted in bit by bit, so a misplaced field or a reversed shift order shows up as a wrong output.

// File: rtl/pla_pkg.sv
package pla_pkg;

    localparam int DEF_N_IN   = 8;
    localparam int DEF_N_PIN  = 10;
    localparam int DEF_N_TERM = 32;

    // Literal code stored as {true_bit, complement_bit}.
    typedef enum logic [1:0] {
        LIT_DC   = 2'b00,
        LIT_COMP = 2'b01,
        LIT_TRUE = 2'b10,
        LIT_KILL = 2'b11
    } lit_e;

    // Per-pin driver view.
    typedef struct packed {
        logic drive;
        logic level;
    } pin_drv_t;

    function automatic int or_base(input int npin);
        return npin;
    endfunction

    function automatic int and_base(input int npin, input int nterm);
        return npin + nterm * npin;
    endfunction

    function automatic int chain_len(input int nin, input int npin, input int nterm);
        return and_base(npin, nterm) + (nterm + npin) * 2 * (nin + npin);
    endfunction

    function automatic logic lit_pass(input lit_e code, input logic x);
        logic r;
        case (code)
            LIT_DC:   r = 1'b1;
            LIT_TRUE: r = x;
            LIT_COMP: r = ~x;
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
    parameter int LEN   = 1842,
    parameter int POL_W = 10
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           shift_en,
    input  logic           sdi,
    output logic [LEN-1:0] cfg_q
);

    localparam logic [LEN-1:0] RST_VAL = {{(LEN-POL_W){1'b1}}, {POL_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= RST_VAL;
        end else if (shift_en) begin
            cfg_q <= {cfg_q[LEN-2:0], sdi};
        end
    end

    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> cfg_q[0] == $past(sdi));                                  // R6
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> cfg_q[LEN-1:1] == $past(cfg_q[LEN-2:0]));                 // R6
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(cfg_q));                                         // R6
    AST_RESET_VIRGIN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cfg_q == RST_VAL);                                      // R7

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int N_VAR = 18,
    parameter int N_ROW = 42
) (
    input  logic [N_VAR-1:0]         vars,
    input  logic [N_ROW*2*N_VAR-1:0] lits,
    output logic [N_ROW-1:0]         rows
);

    localparam int ROW_W = 2 * N_VAR;

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        logic [N_VAR-1:0] hit;
        for (genvar v = 0; v < N_VAR; v++) begin : g_lit
            lit_e code;
            assign code   = lit_e'(lits[r*ROW_W + 2*v +: 2]);
            assign hit[v] = lit_pass(code, vars[v]);
        end
        assign rows[r] = &hit;
    end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
    parameter int N_TERM = 32,
    parameter int N_OUT  = 10
) (
    input  logic [N_TERM-1:0]       terms,
    input  logic [N_TERM*N_OUT-1:0] or_bits,
    input  logic [N_OUT-1:0]        pol,
    output logic [N_OUT-1:0]        levels
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        logic [N_TERM-1:0] sel;
        for (genvar p = 0; p < N_TERM; p++) begin : g_tap
            assign sel[p] = terms[p] & or_bits[p*N_OUT + o];
        end
        assign levels[o] = (|sel) ^ pol[o];
    end

endmodule

// File: rtl/pla_array.sv
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN   = DEF_N_IN,
    parameter int N_PIN  = DEF_N_PIN,
    parameter int N_TERM = DEF_N_TERM
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_en,
    input  logic             cfg_sdi,
    input  logic [N_IN-1:0]  i_in,
    input  logic [N_PIN-1:0] b_in,
    output logic [N_PIN-1:0] b_out,
    output logic [N_PIN-1:0] b_oe
);

    localparam int N_VAR  = N_IN + N_PIN;
    localparam int N_ROW  = N_TERM + N_PIN;
    localparam int AND_W  = N_ROW * 2 * N_VAR;
    localparam int OR_W   = N_TERM * N_PIN;
    localparam int OR_LO  = or_base(N_PIN);
    localparam int AND_LO = and_base(N_PIN, N_TERM);
    localparam int LEN    = chain_len(N_IN, N_PIN, N_TERM);

    logic [LEN-1:0]   cfg_q;
    logic [N_VAR-1:0] vars;
    logic [N_ROW-1:0] rows;
    logic [N_PIN-1:0] levels;
    pin_drv_t [N_PIN-1:0] drv;

    pla_cfg_chain #(.LEN(LEN), .POL_W(N_PIN)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_en),
        .sdi      (cfg_sdi),
        .cfg_q    (cfg_q)
    );

    assign vars = {b_in, i_in};

    pla_and_plane #(.N_VAR(N_VAR), .N_ROW(N_ROW)) u_and (
        .vars (vars),
        .lits (cfg_q[AND_LO +: AND_W]),
        .rows (rows)
    );

    pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_PIN)) u_or (
        .terms   (rows[N_TERM-1:0]),
        .or_bits (cfg_q[OR_LO +: OR_W]),
        .pol     (cfg_q[N_PIN-1:0]),
        .levels  (levels)
    );

    always_comb begin
        for (int k = 0; k < N_PIN; k++) begin
            drv[k].level = levels[k];
            drv[k].drive = rows[N_TERM + k] & ~cfg_en;
            b_out[k]     = drv[k].level;
            b_oe[k]      = drv[k].drive;
        end
    end

    AST_LOAD_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        cfg_en |-> b_oe == '0);                                                // R8
    AST_VIRGIN_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (b_out == '0 && b_oe == '0));                           // R7

endmodule

// File: tb/test_pla_array.sv
module test_pla_array;

    localparam int NI    = 8;
    localparam int NP    = 10;
    localparam int NT    = 32;
    localparam int NV    = NI + NP;
    localparam int NR    = NT + NP;
    localparam int AND_B = NP + NT * NP;
    localparam int CH    = AND_B + NR * 2 * NV;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_en = 1'b0;
    logic          cfg_sdi = 1'b0;
    logic [NI-1:0] i_in = '0;
    logic [NP-1:0] b_in = '0;
    logic [NP-1:0] b_out;
    logic [NP-1:0] b_oe;

    int total = 0;
    int bad = 0;

    logic [CH-1:0] img;
    logic [CH-1:0] cur;

    typedef struct {
        logic [NP-1:0] out;
        logic [NP-1:0] oe;
        string         tag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    pla_array i_pla_array (
        .clk     (clk),
        .rst     (rst),
        .cfg_en  (cfg_en),
        .cfg_sdi (cfg_sdi),
        .i_in    (i_in),
        .b_in    (b_in),
        .b_out   (b_out),
        .b_oe    (b_oe)
    );

    function automatic logic [2*NP-1:0] model(input logic [CH-1:0] c,
                                              input logic [NI-1:0] ii,
                                              input logic [NP-1:0] bi);
        logic [NV-1:0] vars;
        logic [NR-1:0] row;
        logic [NP-1:0] out;
        logic [NP-1:0] oe;
        logic          s;
        vars = {bi, ii};
        for (int r = 0; r < NR; r++) begin
            row[r] = 1'b1;
            for (int v = 0; v < NV; v++) begin
                if (c[AND_B + 2*NV*r + 2*v + 1] && !vars[v]) row[r] = 1'b0;
                if (c[AND_B + 2*NV*r + 2*v] && vars[v]) row[r] = 1'b0;
            end
        end
        for (int o = 0; o < NP; o++) begin
            s = 1'b0;
            for (int p = 0; p < NT; p++) begin
                if (c[NP + NP*p + o] && row[p]) s = 1'b1;
            end
            out[o] = s ^ c[o];
        end
        for (int k = 0; k < NP; k++) oe[k] = row[NT + k];
        return {oe, out};
    endfunction

    function automatic logic [CH-1:0] virgin();
        logic [CH-1:0] c;
        c = '1;
        c[NP-1:0] = '0;
        return c;
    endfunction

    task automatic set_lit(input int t, input int v, input logic [1:0] code);
        img[AND_B + 2*NV*t + 2*v +: 2] = code;
    endtask

    task automatic set_or(input int p, input int o);
        img[NP + NP*p + o] = 1'b1;
    endtask

    task automatic apply(input logic [NI-1:0] ii, input logic [NP-1:0] bi, input string tag);
        exp_t e;
        logic [2*NP-1:0] m;
        @(negedge clk);
        i_in = ii;
        b_in = bi;
        m = model(cur, ii, bi);
        e.out = m[NP-1:0];
        e.oe  = m[2*NP-1:NP];
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic load_cfg();
        @(negedge clk);
        cfg_en  = 1'b1;
        cfg_sdi = img[CH-1];
        #2;
        total++;
        if (b_oe !== '0) begin
            bad++;
            $display("FAIL R8: b_oe during load = %h, expected 000", b_oe);
        end
        for (int i = CH - 1; i >= 0; i--) begin
            cfg_sdi = img[i];
            @(negedge clk);
        end
        cfg_en = 1'b0;
        cur = img;
    endtask

    // Monitor: compares queued expectations between clock edges.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                total++;
                if (b_out !== e.out || b_oe !== e.oe) begin
                    bad++;
                    $display("FAIL %s: b_out=%h exp=%h b_oe=%h exp=%h",
                             e.tag, b_out, e.out, b_oe, e.oe);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur = virgin();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R7: unprogrammed configuration gives all-zero outputs.
        apply(8'hFF, 10'h3FF, "R7");
        apply(8'h00, 10'h000, "R7");

        // Configuration 1: mixed literals, empty sums, polarity, feedback.
        img = '0;
        set_lit(0, 0, 2'b10);
        set_lit(1, 1, 2'b10);
        set_lit(2, 2, 2'b01); set_lit(2, 3, 2'b10);
        set_lit(3, 8, 2'b10); set_lit(3, 4, 2'b10);
        set_lit(4, 5, 2'b11);
        for (int p = 6; p < NT; p++) begin
            set_lit(p, p % NV, 2'b10);
            set_lit(p, (p + 5) % NV, 2'b01);
        end
        set_or(0, 0); set_or(1, 0);
        set_or(0, 1); img[1] = 1'b1;
        img[3] = 1'b1;
        set_or(5, 4);
        set_or(4, 5);
        set_or(3, 6);
        for (int p = 6; p < NT; p++) set_or(p, 7);
        set_or(2, 8); img[8] = 1'b1;
        for (int p = 0; p < NT; p++) if (p != 5) set_or(p, 9);
        for (int k = 0; k < NP; k++) begin
            if (k % 2 == 1) set_lit(NT + k, 7, 2'b10);
        end
        set_lit(NT + 9, 17, 2'b01);
        load_cfg();

        apply(8'h00, 10'h000, "R1");
        apply(8'hFF, 10'h3FF, "R1");
        apply(8'h01, 10'h000, "R3");
        apply(8'h02, 10'h000, "R2");
        apply(8'h18, 10'h001, "R5");
        apply(8'h10, 10'h000, "R5");
        apply(8'h80, 10'h000, "R4");
        apply(8'h80, 10'h200, "R4");
        for (int n = 0; n < 24; n++) begin
            apply(8'($urandom), 10'($urandom), "R2");
        end

        // R9: outputs follow input steps with no edge in between.
        @(negedge clk);
        i_in = 8'h01;
        #1;
        i_in = 8'h00;
        #1;
        total++;
        if (b_out !== model(cur, 8'h00, b_in)
[NP-1:0]) begin
            bad++;
            $display("FAIL R9: b_out=%h, expected %h", b_out, model(cur, 8'h00, b_in)
[NP-1:0]);
        end

        // R6: cfg_sdi toggling with cfg_en low leaves the configuration intact.
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            cfg_sdi = n[0];
        end
        apply(8'h01, 10'h001, "R6");
        apply(8'hA5, 10'h155, "R6");

        // R7: reset in mid-run restores the unprogrammed state.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cur = virgin();
        apply(8'hFF, 10'h3FF, "R7");

        // Configuration 2: every term on every sum, alternating polarity, killed drivers.
        img = '0;
        for (int p = 0; p < NT; p++) begin
            set_lit(p, p % NI, 2'b10);
            set_lit(p, NI + (p / 4) % NP, 2'b01);
            for (int o = 0; o < NP; o++) set_or(p, o);
        end
        for (int o = 0; o < NP; o += 2) img[o] = 1'b1;
        for (int k = 0; k < 3; k++) set_lit(NT + k, k, 2'b11);
        set_lit(NT + 4, NI + 4, 2'b10);
        load_cfg();

        apply(8'h00, 10'h3FF, "R2");
        apply(8'hFF, 10'h000, "R2");
        apply(8'h01, 10'h3FE, "R3");
        apply(8'h00, 10'h010, "R4");
        for (int n = 0; n < 16; n++) begin
            apply(8'($urandom), 10'($urandom), "R2");
        end

        repeat (3) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule